// File: doc/BRIEF.md
# Command Queue Status Port

This block stands between a host register bus and a drawing engine. A host write to any command address is queued in a first-in first-out buffer as an address/data pair. The buffer drains into the engine's register file through a valid/ready handshake, so the host can issue a batch of commands without waiting for the engine.

One status word, read at a fixed address, reports how many queue entries are free, whether the raster pipeline and the frame buffer stages are busy, and two sticky error flags. Software treats the engine as idle only when both busy bits read zero. It reads the free count and keeps a margin of eight entries before it issues a burst. Writing ones to the error bits of the status word clears them. A write that arrives while the queue is full is dropped and raises the overflow flag. A read of any command address raises the read-error flag, because command registers are write-only.

Top module: `cmd_fifo_status`

## Requirements
- R1: After reset the status word reads DEPTH in bits 11:0 with every other bit zero, and cmd_valid_o is low.
- R2: Bits 11:0 of the status word equal DEPTH minus the number of queued entries. The field changes at the clock edge of each accepted push or pop, stays the same when a push and a pop share an edge, and never exceeds DEPTH.
- R3: A host write to any address other than STATUS_ADDR, made while the queue is not full, queues that address and data. Entries leave in arrival order on cmd_addr_o/cmd_data_o. An entry is removed at an edge where cmd_valid_o and cmd_ready_i are both high, and the head stays stable while cmd_ready_i is low.
- R4: A host write to a command address while the queue is full (DEPTH entries, regardless of a pop at that edge) is dropped and sets the sticky overflow flag, bit 31. The queued contents are unchanged.
- R5: A host read of any address other than STATUS_ADDR returns zero and sets the sticky read-error flag, bit 30.
- R6: Bit 24 reports fb_busy_i. Bit 25 reports raster_busy_i ORed with a non-empty queue. Bits 23:12, 29:26 read zero.
- R7: A host write to STATUS_ADDR clears bit 30 and/or bit 31 where its data has a one, leaves a flag whose data bit is zero untouched, and never enters the queue.
- R8: A host read returns its data on host_rdata_o at the clock edge after the read strobe. That value holds until the next read, even when the status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Registered host read data |
| cmd_valid_o | output | 1 | Queue head valid toward the engine |
| cmd_ready_i | input | 1 | Engine accepts the head entry |
| cmd_addr_o | output | ADDR_W | Head entry register address |
| cmd_data_o | output | 32 | Head entry data |
| raster_busy_i | input | 1 | Engine raster pipeline busy |
| fb_busy_i | input | 1 | Engine frame buffer stage busy |

## Verification
The bench fills the queue to exactly zero free entries and then writes once more. A design that let the extra write in, or that did not flag it, would show a seventeenth entry during the drain or a clear bit 31. It shares one clock edge between a push and a pop and checks that the free count stays put, which catches a counter that favours one side. It writes zero to the status word to show that the flags are cleared only by ones and that such a write never costs a queue entry. It also drains the queue with the busy inputs low to show that bit 25 tracks queue occupancy.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned FREE_W     = 12;
  localparam int unsigned BIT_FBBSY  = 24;
  localparam int unsigned BIT_RPBSY  = 25;
  localparam int unsigned BIT_RDERR  = 30;
  localparam int unsigned BIT_OVFL   = 31;
  localparam int unsigned NUM_ERR    = 2;
  // index into the sticky flag vector
  localparam int unsigned ERR_RD     = 0;
  localparam int unsigned ERR_OVF    = 1;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int unsigned WIDTH = 40,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/cmdq_sticky_w1c.sv
module cmdq_sticky_w1c #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;  // a fresh error outranks a clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;
  end
endmodule

// File: rtl/cmd_fifo_status.sv
module cmd_fifo_status
  import cmdq_pkg::*;
#(
  parameter int unsigned          DEPTH       = 16,
  parameter int unsigned          ADDR_W      = 8,
  parameter logic [ADDR_W-1:0]    STATUS_ADDR = 8'hFC,
  localparam int unsigned         ENT_W       = ADDR_W + WORD_W,
  localparam int unsigned         CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [WORD_W-1:0] cmd_data_o,
  input  logic              raster_busy_i,
  input  logic              fb_busy_i
);
  logic              is_status;
  logic              push_en, pop_en, wr_cmd, rd_cmd;
  logic              full, empty;
  logic [CNT_W-1:0]  used;
  logic [ENT_W-1:0]  head;
  logic [NUM_ERR-1:0] err_set, err_clr, err_q;
  logic [FREE_W-1:0] free_cnt;
  logic [WORD_W-1:0] status_w, rdata_q;

  assign is_status = (host_addr_i == STATUS_ADDR);
  assign wr_cmd    = host_wr_i & ~is_status;
  assign rd_cmd    = host_rd_i & ~is_status;
  assign push_en   = wr_cmd & ~full;
  assign pop_en    = cmd_valid_o & cmd_ready_i;

  cmdq_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_en),
    .wdata_i ({host_addr_i, host_wdata_i}),
    .pop_i   (pop_en),
    .rdata_o (head),
    .count_o (used),
    .full_o  (full),
    .empty_o (empty)
  );

  assign cmd_valid_o = ~empty;
  assign cmd_addr_o  = head[ENT_W-1:WORD_W];
  assign cmd_data_o  = head[WORD_W-1:0];

  always_comb begin
    err_set          = '0;
    err_set[ERR_RD]  = rd_cmd;
    err_set[ERR_OVF] = wr_cmd & full;
    err_clr          = '0;
    err_clr[ERR_RD]  = host_wr_i & is_status & host_wdata_i[BIT_RDERR];
    err_clr[ERR_OVF] = host_wr_i & is_status & host_wdata_i[BIT_OVFL];
  end

  cmdq_sticky_w1c #(.N(NUM_ERR)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (err_clr),
    .q_o    (err_q)
  );

  assign free_cnt = FREE_W'(DEPTH) - FREE_W'(used);

  always_comb begin
    status_w            = '0;
    status_w[FREE_W-1:0] = free_cnt;
    status_w[BIT_FBBSY] = fb_busy_i;
    status_w[BIT_RPBSY] = raster_busy_i | ~empty;  // queued work counts as raster activity
    status_w[BIT_RDERR] = err_q[ERR_RD];
    status_w[BIT_OVFL]  = err_q[ERR_OVF];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (host_rd_i) rdata_q <= is_status ? status_w : '0;
  end

  assign host_rdata_o = rdata_q;
endmodule

// File: rtl/cmd_fifo_status_chk.sv
module cmd_fifo_status_chk #(
  parameter int unsigned       DEPTH       = 16,
  parameter int unsigned       ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hFC,
  localparam int unsigned      CNT_W       = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [31:0]       host_wdata_i,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [31:0]       cmd_data_o,
  input logic [CNT_W-1:0]  used,
  input logic [1:0]        err_q
);
  logic st, full_c, push_c, pop_c;
  assign st     = (host_addr_i == STATUS_ADDR);
  assign full_c = (used == CNT_W'(DEPTH));
  assign push_c = host_wr_i & ~st & ~full_c;
  assign pop_c  = cmd_valid_o & cmd_ready_i;

  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= CNT_W'(DEPTH));

  p_count_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_c && !pop_c |=> used == $past(used) + CNT_W'(1));

  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_c && !push_c |=> used == $past(used) - CNT_W'(1));

  p_head_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i && !host_wr_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_data_o));

  p_ovf_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && !st && full_c |=> err_q[1]);

  p_ovf_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q[1] && !(host_wr_i && st && host_wdata_i[31]) |=> err_q[1]);

  p_rderr_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i && !st |=> err_q[0]);

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && st && host_wdata_i[30] && !host_rd_i |=> !err_q[0]);

  p_status_no_push_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && st && !pop_c |=> $stable(used));
endmodule

bind cmd_fifo_status cmd_fifo_status_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_data_o   (cmd_data_o),
  .used         (used),
  .err_q        (err_q)
);

// File: tb/cmd_fifo_status_tb.sv
module cmd_fifo_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [7:0] ST = 8'hFC;

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read+check, 2 busy inputs {raster,fb}
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{2'd1, ST,    32'h0,        32'h0000_0010, 4'd1}, // R1 reset state
    '{2'd0, 8'h10, 32'hA5A50001, 32'h0,         4'd3},
    '{2'd1, ST,    32'h0,        32'h0200_000F, 4'd2}, // R2 one entry used
    '{2'd2, 8'h0,  32'h1,        32'h0,         4'd6},
    '{2'd1, ST,    32'h0,        32'h0300_000F, 4'd6}, // R6 fb busy
    '{2'd2, 8'h0,  32'h2,        32'h0,         4'd6},
    '{2'd1, ST,    32'h0,        32'h0200_000F, 4'd6}, // R6 raster busy
    '{2'd2, 8'h0,  32'h0,        32'h0,         4'd6},
    '{2'd1, 8'h10, 32'h0,        32'h0,         4'd5}, // R5 read of command reg
    '{2'd1, ST,    32'h0,        32'h4200_000F, 4'd5}, // R5 flag set
    '{2'd0, ST,    32'h0,        32'h0,         4'd7},
    '{2'd1, ST,    32'h0,        32'h4200_000F, 4'd7}, // R7 zero leaves flag, no push
    '{2'd0, ST,    32'h4000_0000, 32'h0,        4'd7},
    '{2'd1, ST,    32'h0,        32'h0200_000F, 4'd7}  // R7 cleared
  };

  logic clk = 0, rst_n = 0;
  logic wr = 0, rd = 0, ready = 0, rbusy = 0, fbusy = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic cvalid;
  logic [7:0] caddr;
  logic [31:0] cdata;
  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_fifo_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_rd_i(rd),
    .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .cmd_valid_o(cvalid), .cmd_ready_i(ready), .cmd_addr_o(caddr),
    .cmd_data_o(cdata), .raster_busy_i(rbusy), .fb_busy_i(fbusy)
  );

  function automatic string rname(input int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1;
    @(posedge clk); @(negedge clk);
    wr = 0;
  endtask

  task automatic host_read(input logic [7:0] a);
    addr = a; rd = 1;
    @(posedge clk); @(negedge clk);
    rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid low", {31'b0, cvalid}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: host_write(VEC[i].addr, VEC[i].data);
        2'd1: begin
          host_read(VEC[i].addr);
          check(rname(int'(VEC[i].req)), rdata, VEC[i].exp);
        end
        default: begin
          fbusy = VEC[i].data[0]; rbusy = VEC[i].data[1];
          @(negedge clk);
        end
      endcase
    end

    // R2: fill to zero free entries
    for (int i = 0; i < DEPTH - 1; i++) host_write(8'h11 + 8'(i), 32'hA5A50002 + i);
    host_read(ST);
    check("R2 full", rdata, 32'h0200_0000);

    // R4: overflow write dropped, flag set
    host_write(8'h55, 32'hDEAD_BEEF);
    host_read(ST);
    check("R4 overflow flag", rdata, 32'h8200_0000);
    check("R3 head", {caddr, cdata[23:0]}, {8'h10, 24'hA50001});

    // R3: drain in order; dropped entry must not appear
    ready = 1;
    for (int i = 0; i < DEPTH; i++) begin
      check("R3 order addr", {24'b0, caddr}, {24'b0, 8'h10 + 8'(i)});
      check("R3 order data", cdata, 32'hA5A50001 + i);
      @(posedge clk); @(negedge clk);
    end
    ready = 0;
    check("R3 empty after drain", {31'b0, cvalid}, 32'h0);
    host_read(ST);
    check("R4 sticky", rdata, 32'h8000_0010);

    host_write(ST, 32'h8000_0000);
    host_read(ST);
    check("R7 ovf cleared", rdata, 32'h0000_0010);

    // R2: simultaneous push and pop keeps the count
    host_write(8'h20, 32'h1);
    addr = 8'h21; wdata = 32'h2; wr = 1; ready = 1;
    @(posedge clk); @(negedge clk);
    wr = 0; ready = 0;
    host_read(ST);
    check("R2 push+pop", rdata, 32'h0200_000F);
    check("R3 new head", {24'b0, caddr}, 32'h21);

    // R8: read data holds while status changes
    host_write(8'h22, 32'h3);
    repeat (2) @(negedge clk);
    check("R8 hold", rdata, 32'h0200_000F);
    host_read(ST);
    check("R8 update", rdata, 32'h0200_000E);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule